// File: doc/BRIEF.md
# Conflict-Free Crossbar Packet Forwarder

This block joins a set of on-chip agents through a crossbar that never loses a cycle to arbitration. Each source port has its own packet queue. Every cycle, the oldest packet in each source queue tries to move to the destination port named in the packet. It moves whenever that destination's queue still has a free slot. There is no limit of one winner per destination: several sources can land packets in the same destination queue in one cycle, bounded only by the free slots there.

Space is handed out in order of source index. The lowest-numbered source takes space first, so when a destination cannot hold every contender, the higher-numbered sources wait. A packet that cannot move stays at the front of its queue and tries again in later cycles. Everything behind it in that queue waits too, even when its own destination is idle. The block is meant as an idealised interconnect model inside a larger fabric. It is parameterised in port count, payload width and the depths of both queue kinds.

Top module: `xbar_ideal_fwd`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Source port i accepts a packet on a clock edge where `in_valid[i]` and `in_ready[i]` are both 1. `in_ready[i]` is 0 while that source queue holds IN_DEPTH packets. A packet offered while `in_ready[i]` is 0 is not taken.
- R3: An accepted packet appears at the destination given by its `in_dest` field, with its payload unchanged. With room at the destination, it is visible on `out_valid`/`out_data` after the second rising edge counted from the edge that accepted it.
- R4: In one cycle, every source front packet whose destination has room moves at once, even when several of them share one destination.
- R5: The room at a destination is OUT_DEPTH minus the packets it holds at the start of the cycle. A pop in the same cycle frees room only from the next cycle on.
- R6: When a destination has fewer free slots than contending sources, the lowest-indexed sources are served first.
- R7: A front packet that cannot move stays at its source and is retried every cycle. Packets queued behind it wait, even if their destinations are free.
- R8: Packets from one source to one destination leave in the order accepted. Packets reaching one destination in the same cycle are queued lowest source index first.
- R9: No accepted packet is lost or duplicated. Once all destinations are drained, every accepted packet has been delivered exactly once.
- R10: Asserting `out_pop[k]` while `out_valid[k]` is 0 has no effect: the next packet sent to k still appears after the normal two edges with the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NPORT | Per-source packet offer |
| in_ready | output | NPORT | Per-source queue has room |
| in_dest | input | NPORT*log2(NPORT) | Destination index of each offered packet, source i in slice i |
| in_data | input | NPORT*DATA_W | Payload of each offered packet, source i in slice i |
| out_valid | output | NPORT | Destination queue holds a packet |
| out_pop | input | NPORT | Remove the shown packet from the destination queue |
| out_data | output | NPORT*DATA_W | Oldest packet payload of each destination, port k in slice k |

## Verification
The hardest case to reach from the ports is a front packet held back while a destination is full and is being drained in that very cycle. Holding back would show that stale room is used and that low indices take space first. The bench stops popping one destination and fills it from a different source. It then queues a blocked packet with an unrelated packet behind it, and re-enables popping at a known cycle. The cycle in which `in_ready` rises and the later arrival at the idle destination show the room rule and the head-of-line stall. Orderings such as "1,2,3,0" and "0,1 then 2,3" show same-cycle multi-delivery and index priority. A long random run with per-pair scoreboards covers loss and order.

// File: rtl/xfw_pkg.sv
package xfw_pkg;

   // width of an index selecting one of n ports (at least one bit)
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // width of a counter that must reach the value d
   function automatic int cnt_w(input int d);
      return $clog2(d + 1);
   endfunction

endpackage

// File: rtl/xfw_in_fifo.sv
// Per-source packet queue with a show-ahead head.
module xfw_in_fifo #(
   parameter int PKT_W = 18,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PKT_W-1:0] wr_pkt,
   output logic             full,
   output logic             hd_valid,
   output logic [PKT_W-1:0] hd_pkt,
   input  logic             rd_en
);

   generate
      if (DEPTH == 1) begin : g_single
         logic             held;
         logic [PKT_W-1:0] slot;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= 1'b0;
               slot <= '0;
            end else if (held && rd_en) begin
               held <= 1'b0;
            end else if (!held && wr_en) begin
               held <= 1'b1;
               slot <= wr_pkt;
            end
         end

         assign full     = held;
         assign hd_valid = held;
         assign hd_pkt   = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = xfw_pkg::cnt_w(DEPTH);

         logic [PKT_W-1:0] mem [DEPTH];
         logic [PW-1:0]    rp;
         logic [PW-1:0]    wp;
         logic [CW-1:0]    cnt;
         logic             do_wr;
         logic             do_rd;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         assign do_wr = wr_en && (cnt != CW'(DEPTH));
         assign do_rd = rd_en && (cnt != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rp  <= '0;
               wp  <= '0;
               cnt <= '0;
            end else begin
               if (do_wr) wp <= step(wp);
               if (do_rd) rp <= step(rp);
               cnt <= cnt + CW'(do_wr) - CW'(do_rd);
            end
         end

         always_ff @(posedge clk) begin
            if (do_wr) mem[wp] <= wr_pkt;
         end

         assign full     = (cnt == CW'(DEPTH));
         assign hd_valid = (cnt != '0);
         assign hd_pkt   = mem[rp];
      end
   endgenerate

endmodule

// File: rtl/xfw_out_fifo.sv
// Destination queue taking up to NIN writes per cycle, lowest index first.
module xfw_out_fifo #(
   parameter int NIN    = 4,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4,
   parameter int CW     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NIN-1:0]              push,
   input  logic [NIN-1:0][DATA_W-1:0]  push_data,
   input  logic                        pop,
   output logic                        valid,
   output logic [DATA_W-1:0]           data,
   output logic [CW-1:0]               space
);

   localparam int PW = (DEPTH <= 1) ? 1 : $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     rp;
   logic [PW-1:0]     wp;
   logic [CW-1:0]     cnt;
   logic [PW-1:0]     slot [NIN];
   logic [CW-1:0]     npush;
   logic              do_pop;

   // each writer lands at the write pointer plus the number of lower writers
   always_comb begin
      int rank;
      rank = 0;
      for (int j = 0; j < NIN; j++) begin
         slot[j] = PW'((int'(wp) + rank) % DEPTH);
         if (push[j]) rank = rank + 1;
      end
      npush = CW'(rank);
   end

   assign do_pop = pop && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= PW'((int'(wp) + int'(npush)) % DEPTH);
         if (do_pop) rp <= PW'((int'(rp) + 1) % DEPTH);
         cnt <= cnt + npush - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < NIN; j++) begin
         if (push[j]) mem[slot[j]] <= push_data[j];
      end
   end

   assign valid = (cnt != '0);
   assign data  = mem[rp];
   assign space = CW'(DEPTH) - cnt;

endmodule

// File: rtl/xfw_alloc.sv
// Walks sources in ascending order, spending destination room as it goes.
module xfw_alloc #(
   parameter int NPORT = 4,
   parameter int DW    = 2,
   parameter int CW    = 3
) (
   input  logic [NPORT-1:0]                  head_valid,
   input  logic [NPORT-1:0][DW-1:0]          head_dest,
   input  logic [NPORT-1:0][CW-1:0]          space,
   output logic [NPORT-1:0]                  grant,
   output logic [NPORT-1:0][NPORT-1:0]       route
);

   logic [CW-1:0] left [NPORT];

   always_comb begin
      for (int k = 0; k < NPORT; k++) left[k] = space[k];
      grant = '0;
      route = '0;
      for (int i = 0; i < NPORT; i++) begin
         if (head_valid[i] && (left[head_dest[i]] != '0)) begin
            grant[i]                  = 1'b1;
            route[head_dest[i]][i]    = 1'b1;
            left[head_dest[i]]        = left[head_dest[i]] - 1'b1;
         end
      end
   end

endmodule

// File: rtl/xbar_ideal_fwd.sv
module xbar_ideal_fwd #(
   parameter int NPORT     = 4,
   parameter int DATA_W    = 16,
   parameter int IN_DEPTH  = 4,
   parameter int OUT_DEPTH = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [NPORT-1:0]                       in_valid,
   output logic [NPORT-1:0]                       in_ready,
   input  logic [NPORT*xfw_pkg::idx_w(NPORT)-1:0] in_dest,
   input  logic [NPORT*DATA_W-1:0]                in_data,
   output logic [NPORT-1:0]                       out_valid,
   input  logic [NPORT-1:0]                       out_pop,
   output logic [NPORT*DATA_W-1:0]                out_data
);

   localparam int DW    = xfw_pkg::idx_w(NPORT);
   localparam int CW    = xfw_pkg::cnt_w(OUT_DEPTH);
   localparam int PKT_W = DW + DATA_W;

   generate
      if (NPORT < 2 || (NPORT & (NPORT - 1)) != 0) begin : g_bad_nport
         $error("NPORT must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (IN_DEPTH < 1 || OUT_DEPTH < 1) begin : g_bad_depth
         $error("queue depths must be positive");
      end
   endgenerate

   logic [NPORT-1:0]                  head_valid;
   logic [NPORT-1:0][PKT_W-1:0]       head_pkt;
   logic [NPORT-1:0][DW-1:0]          head_dest;
   logic [NPORT-1:0][DATA_W-1:0]      head_data;
   logic [NPORT-1:0]                  src_full;
   logic [NPORT-1:0]                  grant;
   logic [NPORT-1:0][NPORT-1:0]       route;
   logic [NPORT-1:0][CW-1:0]          space;

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_src
         xfw_in_fifo #(
            .PKT_W (PKT_W),
            .DEPTH (IN_DEPTH)
         ) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (in_valid[i]),
            .wr_pkt   ({in_dest[i*DW +: DW], in_data[i*DATA_W +: DATA_W]}),
            .full     (src_full[i]),
            .hd_valid (head_valid[i]),
            .hd_pkt   (head_pkt[i]),
            .rd_en    (grant[i])
         );
         assign in_ready[i]  = !src_full[i];
         assign head_dest[i] = head_pkt[i][PKT_W-1:DATA_W];
         assign head_data[i] = head_pkt[i][DATA_W-1:0];
      end
   endgenerate

   xfw_alloc #(
      .NPORT (NPORT),
      .DW    (DW),
      .CW    (CW)
   ) u_alloc (
      .head_valid (head_valid),
      .head_dest  (head_dest),
      .space      (space),
      .grant      (grant),
      .route      (route)
   );

   generate
      for (genvar k = 0; k < NPORT; k++) begin : g_dst
         xfw_out_fifo #(
            .NIN    (NPORT),
            .DATA_W (DATA_W),
            .DEPTH  (OUT_DEPTH),
            .CW     (CW)
         ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (route[k]),
            .push_data (head_data),
            .pop       (out_pop[k]),
            .valid     (out_valid[k]),
            .data      (out_data[k*DATA_W +: DATA_W]),
            .space     (space[k])
         );
      end
   endgenerate

endmodule

// File: rtl/xfw_checker.sv
module xfw_checker #(
   parameter int NPORT  = 4,
   parameter int DATA_W = 16,
   parameter int PKT_W  = 18,
   parameter int CW     = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NPORT-1:0]            in_ready,
   input logic [NPORT-1:0]            out_valid,
   input logic [NPORT-1:0]            head_valid,
   input logic [NPORT-1:0][PKT_W-1:0] head_pkt,
   input logic [NPORT-1:0]            grant,
   input logic [NPORT-1:0][CW-1:0]    space
);

   localparam int DW = PKT_W - DATA_W;

   logic [DW-1:0] dst      [NPORT];
   logic [CW-1:0] lower_n  [NPORT];
   logic [CW-1:0] routed_n [NPORT];

   always_comb begin
      for (int i = 0; i < NPORT; i++) dst[i] = head_pkt[i][PKT_W-1:DATA_W];
      for (int i = 0; i < NPORT; i++) begin
         lower_n[i] = '0;
         for (int j = 0; j < i; j++)
            if (grant[j] && dst[j] == dst[i]) lower_n[i] = lower_n[i] + 1'b1;
      end
      for (int k = 0; k < NPORT; k++) begin
         routed_n[k] = '0;
         for (int j = 0; j < NPORT; j++)
            if (grant[j] && int'(dst[j]) == k) routed_n[k] = routed_n[k] + 1'b1;
      end
   end

   // R1: held in reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (out_valid == '0 && in_ready == '1)
            else $error("reset state wrong");
      end
   end

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_src
         // R7: a blocked head packet stays put
         assert_blocked_head_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid[i] && !grant[i]) |=> (head_valid[i] && $stable(head_pkt[i])));
         // R6: a blocked source sees its room used up by lower sources only
         assert_low_index_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid[i] && !grant[i]) |-> (lower_n[i] == space[dst[i]]));
      end
      for (genvar k = 0; k < NPORT; k++) begin : g_dst
         // R5: never more moves to a destination than its room
         assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            routed_n[k] <= space[k]);
      end
   endgenerate

endmodule

bind xbar_ideal_fwd xfw_checker #(
   .NPORT  (NPORT),
   .DATA_W (DATA_W),
   .PKT_W  (PKT_W),
   .CW     (CW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .head_valid (head_valid),
   .head_pkt   (head_pkt),
   .grant      (grant),
   .space      (space)
);

// File: tb/sim_xbar_ideal_fwd.sv
module sim_xbar_ideal_fwd;

   localparam int N  = 4;
   localparam int DW = 2;
   localparam int W  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N-1:0]   in_ready;
   logic [N*DW-1:0] in_dest = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   out_valid;
   logic [N-1:0]   out_pop = '0;
   logic [N*W-1:0] out_data;

   logic [N-1:0]   allow = '0;
   logic [N-1:0]   spurious = '0;
   int             total = 0;
   int             bad = 0;
   int             seq_no = 0;
   logic [W-1:0]   sb   [N*N][$];
   logic [W-1:0]   plog [N][$];

   always #4 clk = ~clk;

   xbar_ideal_fwd #(.NPORT(N), .DATA_W(W), .IN_DEPTH(4), .OUT_DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
      .out_pop(out_pop), .out_data(out_data));

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // driver: offer one packet on source s, record it if it will be taken
   task automatic offer(input int s, input int d);
      logic [W-1:0] v;
      v = {4'(s), 12'(seq_no)};
      seq_no++;
      in_valid[s] = 1'b1;
      in_dest[s*DW +: DW] = DW'(d);
      in_data[s*W +: W] = v;
      if (in_ready[s]) sb[s*N + d].push_back(v);
   endtask

   task automatic send_mask(input logic [N-1:0] m, input int d);
      for (int s = 0; s < N; s++) if (m[s]) offer(s, d);
      tick();
      in_valid = '0;
   endtask

   // monitor: pops allowed outputs and compares against per-pair queues
   always @(negedge clk) begin
      for (int k = 0; k < N; k++) begin
         if (out_valid[k] && allow[k]) begin
            logic [W-1:0] got;
            int pr;
            got = out_data[k*W +: W];
            pr = int'(got[15:12]) * N + k;
            if (sb[pr].size() == 0) chk("R9 unexpected packet", got, 0);
            else chk("R8 pair order/R3 data", got, sb[pr].pop_front());
            plog[k].push_back(got);
            out_pop[k] <= 1'b1;
         end else begin
            out_pop[k] <= spurious[k];
         end
      end
   end

   task automatic chk_srcs(input string tag, input int k, input int exp [$]);
      chk({tag, " count"}, plog[k].size(), exp.size());
      for (int i = 0; i < exp.size() && i < plog[k].size(); i++)
         chk({tag, " source order"}, plog[k][i][15:12], exp[i]);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int left;
      repeat (3) tick();
      // R1: reset state, during and after reset
      chk("R1 out_valid in reset", out_valid, 0);
      chk("R1 in_ready in reset", in_ready, 4'hF);
      rst_n = 1'b1;
      tick();
      chk("R1 out_valid after reset", out_valid, 0);
      chk("R1 in_ready after reset", in_ready, 4'hF);

      // R10: pops on an empty output are ignored
      spurious[1] = 1'b1;
      repeat (3) tick();
      chk("R10 empty output after stray pops", out_valid[1], 0);
      spurious[1] = 1'b0;
      tick();
      offer(0, 1);
      tick();
      in_valid = '0;
      chk("R3 not visible after one edge", out_valid[1], 0);
      tick();
      chk("R10 R3 visible after two edges", out_valid[1], 1);
      chk("R10 R3 payload", out_data[1*W +: W], sb[0*N + 1][0]);
      allow[1] = 1'b1;
      repeat (3) tick();
      allow = '0;

      // R4 R8: three sources hit output 2 together, source 0 one cycle later
      plog[2].delete();
      send_mask(4'b1110, 2);
      send_mask(4'b0001, 2);
      chk("R4 output 2 filled", out_valid[2], 1);
      allow[2] = 1'b1;
      repeat (6) tick();
      chk_srcs("R4 R8 same-cycle delivery", 2, '{1, 2, 3, 0});
      allow = '0;

      // R6: two free slots, four contenders
      plog[1].delete();
      send_mask(4'b1000, 1);
      send_mask(4'b1000, 1);
      repeat (3) tick();
      send_mask(4'b1111, 1);
      repeat (2) tick();
      allow[1] = 1'b1;
      repeat (10) tick();
      chk_srcs("R6 low index first", 1, '{3, 3, 0, 1, 2, 3});
      allow = '0;

      // R2 R5 R7: output 3 full, source 0 blocked with a packet for 0 behind
      for (int i = 0; i < 4; i++) send_mask(4'b0010, 3);
      repeat (3) tick();
      send_mask(4'b0001, 3);
      send_mask(4'b0001, 0);
      send_mask(4'b0001, 3);
      send_mask(4'b0001, 3);
      chk("R2 ready low when source full", in_ready[0], 0);
      send_mask(4'b0001, 0);  // refused: not recorded, must never appear
      repeat (2) tick();
      chk("R7 packet behind blocked head waits", out_valid[0], 0);
      allow[3] = 1'b1;
      tick();
      tick();
      chk("R5 same-cycle pop gives no room", in_ready[0], 0);
      tick();
      chk("R5 room appears next cycle", in_ready[0], 1);
      tick();
      chk("R7 trailing packet released", out_valid[0], 1);
      allow = '1;
      repeat (20) tick();

      // R9: random traffic with random back-pressure
      for (int c = 0; c < 1500; c++) begin
         allow = 4'($urandom);
         for (int s = 0; s < N; s++)
            if ($urandom % 3 != 0) offer(s, int'($urandom % N));
         tick();
         in_valid = '0;
      end
      allow = '1;
      repeat (60) tick();
      left = 0;
      for (int p = 0; p < N * N; p++) left += sb[p].size();
      chk("R9 all accepted packets delivered", left, 0);
      chk("R9 outputs drained", out_valid, 0);

      summary();
      $finish;
   end

endmodule